// File: doc/BRIEF.md
# Status-Register Flash Command Sequencer

This block turns single host requests, either one word program or one sector erase, into the command and data cycles that an asynchronous NOR flash bus with a status-register command set expects. The data bus is built from several devices of equal width placed side by side (two 16-bit devices on a 32-bit bus by default). Each command byte therefore goes into the low byte of every device lane, and the status read back is decoded for all lanes at once.

A program first reads the destination and refuses to proceed if the word cannot be reached by clearing bits only. Otherwise it sends the command prefix and the data word. Both kinds of operation then poll the status word until every device reports ready, or until a cycle budget runs out, in which case the operation is suspended. The flash is always returned to read mode before the host sees a one-cycle completion pulse carrying a result code. The host supplies the sector base address for an erase.

Top module: `flseq_top`

## Requirements
- R1: After reset, `busy`, `done`, `fl_wr` and `fl_rd` are all low.
- R2: A program request first reads the destination. If (read value AND new data) differs from the new data, the operation finishes with result 2 and no write cycle is issued.
- R3: An accepted program writes, all to the destination address and in this order: 0x00500050, 0x00FF00FF, 0x00400040, then the data word. After polling ends without timeout it writes 0x00500050 then 0x00FF00FF.
- R4: An erase writes 0x00500050, 0x00200020 and 0x00D000D0 to the given sector address in that order, and after polling ends without timeout it writes 0x00FF00FF.
- R5: Polling reads the target address and only ends as ready when every lane's ready bit (bit 7 of each 16-bit lane, mask 0x00800080) is set. A status word with only some lanes ready keeps the poll going.
- R6: When the poll budget (`PGM_TMO_CYC` for program, `ERS_TMO_CYC` for erase) is used up without ready, the block writes suspend 0x00B000B0 and then the normal closing writes (0x00500050, 0x00FF00FF for program; 0x00FF00FF for erase), and the result is 1.
- R7: A program that becomes ready with any lane's error bit set (bit 4 of a lane, mask 0x00100010) returns result 1 and still issues its closing writes.
- R8: After the erase-confirm write, no read is issued for at least `SETTLE_CYC` cycles.
- R9: `busy` rises in the cycle after an accepted request and stays high through the `done` cycle. `done` is a one-cycle pulse. Requests made while busy are ignored, and no bus cycle occurs while idle.
- R10: Result codes on `result` while `done` is high: 0 success, 1 timeout or device error, 2 not erased. Code 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_erase | input | 1 | 1 = sector erase, 0 = word program |
| req_addr | input | AW | Word address (sector base for erase) |
| req_data | input | BUS_W | Word to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | Result code, valid with done |
| fl_addr | output | AW | Flash word address |
| fl_wdata | output | BUS_W | Flash write data |
| fl_wr | output | 1 | One-cycle flash write strobe |
| fl_rd | output | 1 | One-cycle flash read strobe |
| fl_rdata | input | BUS_W | Read data, valid the cycle after fl_rd |

## Verification
Every bus cycle leaves a registered state, so a write or read strobe is seen at the first rising edge after the state is entered. Read data is expected one cycle after `fl_rd`. `busy` appears one edge after the request and `done` two edges after the last closing write. The bench drives and samples at falling edges and logs every bus cycle with its cycle stamp. It compares whole command orders, counts poll reads against the number of busy status words it returned, and measures the confirm-to-first-read gap in cycles instead of waiting a fixed time. Results are read only in the cycle where `done` is sampled high.

// File: rtl/flseq_pkg.sv
package flseq_pkg;

  typedef enum logic [4:0] {
    S_IDLE, S_PRE_RD, S_PRE_EV,
    S_PCLR, S_PRDM, S_PSET, S_PDAT,
    S_ECLR, S_ESET, S_ECNF, S_SETTLE,
    S_POLL_RD, S_POLL_EV, S_SUSP,
    S_TCLR, S_TRDM, S_DONE
  } seq_state_t;

  typedef enum logic [2:0] {
    CMD_CLR, CMD_RDM, CMD_PSET, CMD_ESET, CMD_ECNF, CMD_SUSP, CMD_DATA
  } cmd_sel_t;

  localparam logic [7:0] OPC_CLR  = 8'h50;
  localparam logic [7:0] OPC_RDM  = 8'hFF;
  localparam logic [7:0] OPC_PSET = 8'h40;
  localparam logic [7:0] OPC_ESET = 8'h20;
  localparam logic [7:0] OPC_ECNF = 8'hD0;
  localparam logic [7:0] OPC_SUSP = 8'hB0;

  localparam int RDY_BIT = 7;
  localparam int ERR_BIT = 4;

  localparam logic [1:0] RES_OK    = 2'd0;
  localparam logic [1:0] RES_FAIL  = 2'd1;
  localparam logic [1:0] RES_DIRTY = 2'd2;

endpackage

// File: rtl/flseq_cmdgen.sv
module flseq_cmdgen
  import flseq_pkg::*;
#(
  parameter int DEV_CNT = 2,
  parameter int DEV_W   = 16,
  localparam int BUS_W  = DEV_CNT * DEV_W
) (
  input  cmd_sel_t           sel,
  input  logic [BUS_W-1:0]   data,
  output logic [BUS_W-1:0]   wdata
);

  logic [7:0]       opc;
  logic [BUS_W-1:0] lanes;

  always_comb begin
    case (sel)
      CMD_CLR:  opc = OPC_CLR;
      CMD_RDM:  opc = OPC_RDM;
      CMD_PSET: opc = OPC_PSET;
      CMD_ESET: opc = OPC_ESET;
      CMD_ECNF: opc = OPC_ECNF;
      CMD_SUSP: opc = OPC_SUSP;
      default:  opc = OPC_RDM;
    endcase
  end

  for (genvar g = 0; g < DEV_CNT; g++) begin : g_lane
    assign lanes[g*DEV_W +: DEV_W] = {{(DEV_W-8){1'b0}}, opc};
  end

  assign wdata = (sel == CMD_DATA) ? data : lanes;

endmodule

// File: rtl/flseq_status.sv
module flseq_status
  import flseq_pkg::*;
#(
  parameter int DEV_CNT = 2,
  parameter int DEV_W   = 16,
  localparam int BUS_W  = DEV_CNT * DEV_W
) (
  input  logic [BUS_W-1:0] rdata,
  input  logic [BUS_W-1:0] data,
  output logic             all_ready,
  output logic             any_err,
  output logic             fits
);

  logic [DEV_CNT-1:0] rdy;
  logic [DEV_CNT-1:0] err;

  for (genvar g = 0; g < DEV_CNT; g++) begin : g_dec
    assign rdy[g] = rdata[g*DEV_W + RDY_BIT];
    assign err[g] = rdata[g*DEV_W + ERR_BIT];
  end

  assign all_ready = &rdy;
  assign any_err   = |err;
  assign fits      = ((rdata & data) == data);

endmodule

// File: rtl/flseq_tmr.sv
module flseq_tmr #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          zero
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/flseq_ctrl.sv
module flseq_ctrl
  import flseq_pkg::*;
#(
  parameter int AW          = 22,
  parameter int BUS_W       = 32,
  parameter int TW          = 8,
  parameter int PGM_TMO_CYC = 100,
  parameter int ERS_TMO_CYC = 100,
  parameter int SETTLE_CYC  = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_erase,
  input  logic [AW-1:0]    req_addr,
  input  logic [BUS_W-1:0] req_data,
  input  logic             all_ready,
  input  logic             any_err,
  input  logic             fits,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [TW-1:0]    tmr_val,
  output cmd_sel_t         cmd_sel,
  output logic             bus_wr,
  output logic             bus_rd,
  output logic [AW-1:0]    tgt_addr,
  output logic [BUS_W-1:0] tgt_data,
  output logic             busy,
  output logic             done,
  output logic [1:0]       result
);

  seq_state_t       st_q, st_d;
  logic             erase_q;
  logic [AW-1:0]    addr_q;
  logic [BUS_W-1:0] data_q;
  logic [1:0]       res_q, res_d;
  logic             cap_en, res_en;

  always_comb begin
    st_d     = st_q;
    cap_en   = 1'b0;
    res_en   = 1'b0;
    res_d    = res_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cmd_sel  = CMD_CLR;
    bus_wr   = 1'b0;
    bus_rd   = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (req_valid) begin
          cap_en = 1'b1;
          st_d   = req_erase ? S_ECLR : S_PRE_RD;
        end
      end
      S_PRE_RD: begin
        bus_rd = 1'b1;
        st_d   = S_PRE_EV;
      end
      S_PRE_EV: begin
        if (!fits) begin
          res_en = 1'b1;
          res_d  = RES_DIRTY;
          st_d   = S_DONE;
        end else begin
          st_d = S_PCLR;
        end
      end
      S_PCLR: begin
        bus_wr = 1'b1; cmd_sel = CMD_CLR;  st_d = S_PRDM;
      end
      S_PRDM: begin
        bus_wr = 1'b1; cmd_sel = CMD_RDM;  st_d = S_PSET;
      end
      S_PSET: begin
        bus_wr = 1'b1; cmd_sel = CMD_PSET; st_d = S_PDAT;
      end
      S_PDAT: begin
        bus_wr   = 1'b1;
        cmd_sel  = CMD_DATA;
        tmr_load = 1'b1;
        tmr_val  = TW'(PGM_TMO_CYC);
        st_d     = S_POLL_RD;
      end
      S_ECLR: begin
        bus_wr = 1'b1; cmd_sel = CMD_CLR;  st_d = S_ESET;
      end
      S_ESET: begin
        bus_wr = 1'b1; cmd_sel = CMD_ESET; st_d = S_ECNF;
      end
      S_ECNF: begin
        bus_wr   = 1'b1;
        cmd_sel  = CMD_ECNF;
        tmr_load = 1'b1;
        tmr_val  = TW'(SETTLE_CYC);
        st_d     = S_SETTLE;
      end
      S_SETTLE: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          tmr_val  = TW'(ERS_TMO_CYC);
          st_d     = S_POLL_RD;
        end
      end
      S_POLL_RD: begin
        bus_rd = 1'b1;
        st_d   = S_POLL_EV;
      end
      S_POLL_EV: begin
        if (all_ready) begin
          res_en = 1'b1;
          res_d  = (!erase_q && any_err) ? RES_FAIL : RES_OK;
          st_d   = erase_q ? S_TRDM : S_TCLR;
        end else if (tmr_zero) begin
          res_en = 1'b1;
          res_d  = RES_FAIL;
          st_d   = S_SUSP;
        end else begin
          st_d = S_POLL_RD;
        end
      end
      S_SUSP: begin
        bus_wr  = 1'b1;
        cmd_sel = CMD_SUSP;
        st_d    = erase_q ? S_TRDM : S_TCLR;
      end
      S_TCLR: begin
        bus_wr = 1'b1; cmd_sel = CMD_CLR; st_d = S_TRDM;
      end
      S_TRDM: begin
        bus_wr = 1'b1; cmd_sel = CMD_RDM; st_d = S_DONE;
      end
      S_DONE: begin
        st_d = S_IDLE;
      end
      default: begin
        st_d = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erase_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (cap_en) begin
      erase_q <= req_erase;
      addr_q  <= req_addr;
      data_q  <= req_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= RES_OK;
    else if (res_en) res_q <= res_d;
  end

  assign tgt_addr = addr_q;
  assign tgt_data = data_q;
  assign busy     = (st_q != S_IDLE);
  assign done     = (st_q == S_DONE);
  assign result   = res_q;

endmodule

// File: rtl/flseq_top.sv
module flseq_top
  import flseq_pkg::*;
#(
  parameter int AW          = 22,
  parameter int DEV_CNT     = 2,
  parameter int DEV_W       = 16,
  parameter int PGM_TMO_CYC = 50000,
  parameter int ERS_TMO_CYC = 1000000000,
  parameter int SETTLE_CYC  = 250000,
  localparam int BUS_W      = DEV_CNT * DEV_W,
  localparam int MAX_A      = (PGM_TMO_CYC > ERS_TMO_CYC) ? PGM_TMO_CYC : ERS_TMO_CYC,
  localparam int MAX_CYC    = (MAX_A > SETTLE_CYC) ? MAX_A : SETTLE_CYC,
  localparam int TW         = $clog2(MAX_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_erase,
  input  logic [AW-1:0]    req_addr,
  input  logic [BUS_W-1:0] req_data,
  output logic             busy,
  output logic             done,
  output logic [1:0]       result,
  output logic [AW-1:0]    fl_addr,
  output logic [BUS_W-1:0] fl_wdata,
  output logic             fl_wr,
  output logic             fl_rd,
  input  logic [BUS_W-1:0] fl_rdata
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             all_ready, any_err, fits, tmr_zero, tmr_load;
  logic [TW-1:0]    tmr_val;
  cmd_sel_t         cmd_sel;
  logic [BUS_W-1:0] tgt_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  flseq_ctrl #(
    .AW(AW), .BUS_W(BUS_W), .TW(TW),
    .PGM_TMO_CYC(PGM_TMO_CYC), .ERS_TMO_CYC(ERS_TMO_CYC), .SETTLE_CYC(SETTLE_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_int_n),
    .req_valid(req_valid), .req_erase(req_erase),
    .req_addr(req_addr), .req_data(req_data),
    .all_ready(all_ready), .any_err(any_err), .fits(fits),
    .tmr_zero(tmr_zero), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .cmd_sel(cmd_sel), .bus_wr(fl_wr), .bus_rd(fl_rd),
    .tgt_addr(fl_addr), .tgt_data(tgt_data),
    .busy(busy), .done(done), .result(result)
  );

  flseq_status #(.DEV_CNT(DEV_CNT), .DEV_W(DEV_W)) u_status (
    .rdata(fl_rdata), .data(tgt_data),
    .all_ready(all_ready), .any_err(any_err), .fits(fits)
  );

  flseq_cmdgen #(.DEV_CNT(DEV_CNT), .DEV_W(DEV_W)) u_cmdgen (
    .sel(cmd_sel), .data(tgt_data), .wdata(fl_wdata)
  );

  flseq_tmr #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_int_n), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
  );

endmodule

// File: rtl/flseq_chk.sv
module flseq_chk #(
  parameter int DEV_CNT    = 2,
  parameter int DEV_W      = 16,
  parameter int SETTLE_CYC = 100,
  localparam int BUS_W     = DEV_CNT * DEV_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             busy,
  input logic             done,
  input logic [1:0]       result,
  input logic             fl_wr,
  input logic             fl_rd,
  input logic [BUS_W-1:0] fl_wdata
);

  logic [BUS_W-1:0] cnf_word;
  always_comb begin
    cnf_word = '0;
    for (int i = 0; i < DEV_CNT; i++) cnf_word[i*DEV_W +: 8] = 8'hD0;
  end

  logic        armed_q;
  logic [31:0] gap_q;
  logic        wrote_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      gap_q   <= '0;
      wrote_q <= 1'b0;
    end else begin
      if (fl_wr && busy && fl_wdata == cnf_word) begin
        armed_q <= 1'b1;
        gap_q   <= 32'd1;
      end else begin
        if (done) armed_q <= 1'b0;
        if (gap_q != 32'hFFFF_FFFF) gap_q <= gap_q + 32'd1;
      end
      if (!busy)      wrote_q <= 1'b0;
      else if (fl_wr) wrote_q <= 1'b1;
    end
  end

  AST_IDLE_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!fl_wr && !fl_rd)); // R9
  AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> busy); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R9
  AST_RES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result != 2'd3)); // R10
  AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_rd && armed_q) |-> (gap_q >= 32'(SETTLE_CYC))); // R8
  AST_DIRTY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == 2'd2) |-> !wrote_q); // R2

endmodule

bind flseq_top flseq_chk #(
  .DEV_CNT(DEV_CNT), .DEV_W(DEV_W), .SETTLE_CYC(SETTLE_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
  .result(result), .fl_wr(fl_wr), .fl_rd(fl_rd), .fl_wdata(fl_wdata)
);

// File: tb/flseq_top_bench.sv
module flseq_top_bench;

  localparam int AW = 22;
  localparam int PGM_T = 40;
  localparam int ERS_T = 60;
  localparam int SETL  = 100;

  localparam logic [31:0] W_CLR  = 32'h00500050;
  localparam logic [31:0] W_RDM  = 32'h00FF00FF;
  localparam logic [31:0] W_PSET = 32'h00400040;
  localparam logic [31:0] W_ESET = 32'h00200020;
  localparam logic [31:0] W_ECNF = 32'h00D000D0;
  localparam logic [31:0] W_SUSP = 32'h00B000B0;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_erase;
  logic [AW-1:0] req_addr;
  logic [31:0] req_data;
  logic busy, done;
  logic [1:0] result;
  logic [AW-1:0] fl_addr;
  logic [31:0] fl_wdata, fl_rdata;
  logic fl_wr, fl_rd;

  always #2 clk = ~clk;

  flseq_top #(.AW(AW), .PGM_TMO_CYC(PGM_T), .ERS_TMO_CYC(ERS_T), .SETTLE_CYC(SETL)) u_flseq_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_erase(req_erase),
    .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done), .result(result),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_wr(fl_wr), .fl_rd(fl_rd), .fl_rdata(fl_rdata)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // flash model with a bus log
  logic [31:0] mem [16];
  logic        rd_mode;
  logic        pgm_armed;
  int          busy_left;
  logic [31:0] err_inj;
  int          log_n, rd_n, cnf_stamp, first_rd_stamp;
  logic [AW-1:0] log_a [32];
  logic [31:0]   log_d [32];

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (fl_wr) begin
      if (log_n < 32) begin
        log_a[log_n] <= fl_addr;
        log_d[log_n] <= fl_wdata;
      end
      log_n <= log_n + 1;
      if (pgm_armed) begin
        mem[fl_addr[3:0]] <= mem[fl_addr[3:0]] & fl_wdata;
        pgm_armed <= 1'b0;
        rd_mode <= 1'b0;
      end else if (fl_wdata == W_RDM) rd_mode <= 1'b1;
      else if (fl_wdata == W_PSET) pgm_armed <= 1'b1;
      else if (fl_wdata == W_ECNF) begin
        mem[fl_addr[3:0]] <= 32'hFFFF_FFFF;
        rd_mode <= 1'b0;
        cnf_stamp <= cyc;
      end else if (fl_wdata != W_CLR) rd_mode <= 1'b0;
    end
    if (fl_rd) begin
      rd_n <= rd_n + 1;
      if (first_rd_stamp < 0 && cnf_stamp >= 0) first_rd_stamp <= cyc;
      if (rd_mode) fl_rdata <= mem[fl_addr[3:0]];
      else if (busy_left > 0) begin
        fl_rdata <= 32'h00000080;          // one lane ready, the other not
        busy_left <= busy_left - 1;
      end else fl_rdata <= 32'h00800080 | err_inj;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    @(negedge clk);
    log_n = 0; rd_n = 0; cnf_stamp = -1; first_rd_stamp = -1;
    rd_mode = 1'b1; pgm_armed = 1'b0;
  endtask

  task automatic run_op(input logic er, input logic [AW-1:0] a, input logic [31:0] d,
                        output logic [1:0] res);
    bit seen = 0;
    @(negedge clk);
    req_valid = 1'b1; req_erase = er; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    res = 2'd3;
    for (int k = 0; k < 5000 && !seen; k++) begin
      if (done) begin seen = 1; res = result; end
      else @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic chk_wr(input int i, input logic [AW-1:0] a, input logic [31:0] d, input string req);
    check(log_a[i] == a, req, $sformatf("write %0d addr", i), 32'(log_a[i]), 32'(a));
    check(log_d[i] == d, req, $sformatf("write %0d data", i), log_d[i], d);
  endtask

  task automatic t_reset();
    check(!busy && !done, "R1", "busy/done after reset", {30'd0, busy, done}, 32'd0);
    check(!fl_wr && !fl_rd, "R1", "bus strobes after reset", {30'd0, fl_wr, fl_rd}, 32'd0);
  endtask

  task automatic t_prog_ok();
    logic [1:0] r;
    clear_log();
    mem[3] = 32'hFFFF_FFFF; busy_left = 3; err_inj = 0;
    run_op(1'b0, 22'd3, 32'h1234_A5A5, r);
    check(r == 2'd0, "R10", "program ok result", 32'(r), 32'd0);
    check(log_n == 6, "R3", "program write count", 32'(log_n), 32'd6);
    chk_wr(0, 3, W_CLR, "R3"); chk_wr(1, 3, W_RDM, "R3");
    chk_wr(2, 3, W_PSET, "R3"); chk_wr(3, 3, 32'h1234_A5A5, "R3");
    chk_wr(4, 3, W_CLR, "R3"); chk_wr(5, 3, W_RDM, "R3");
    check(rd_n == 5, "R5", "reads: precheck + 3 half-ready + 1 ready", 32'(rd_n), 32'd5);
    check(mem[3] == 32'h1234_A5A5, "R3", "programmed word", mem[3], 32'h1234_A5A5);
  endtask

  task automatic t_not_erased();
    logic [1:0] r;
    clear_log();
    mem[5] = 32'h0000_FFFF; busy_left = 0; err_inj = 0;
    run_op(1'b0, 22'd5, 32'h0001_0001, r);
    check(r == 2'd2, "R2", "not erased result", 32'(r), 32'd2);
    check(log_n == 0, "R2", "no writes issued", 32'(log_n), 32'd0);
    check(rd_n == 1, "R2", "single precheck read", 32'(rd_n), 32'd1);
    check(mem[5] == 32'h0000_FFFF, "R2", "word untouched", mem[5], 32'h0000_FFFF);
  endtask

  task automatic t_prog_err();
    logic [1:0] r;
    clear_log();
    mem[6] = 32'hFFFF_FFFF; busy_left = 1; err_inj = 32'h0000_0010;
    run_op(1'b0, 22'd6, 32'h0F0F_0F0F, r);
    check(r == 2'd1, "R7", "error bit result", 32'(r), 32'd1);
    check(log_n == 6, "R7", "closing writes present", 32'(log_n), 32'd6);
    chk_wr(4, 6, W_CLR, "R7"); chk_wr(5, 6, W_RDM, "R7");
    err_inj = 0;
  endtask

  task automatic t_prog_tmo();
    logic [1:0] r;
    clear_log();
    mem[7] = 32'hFFFF_FFFF; busy_left = 100000; err_inj = 0;
    run_op(1'b0, 22'd7, 32'h5555_AAAA, r);
    check(r == 2'd1, "R6", "program timeout result", 32'(r), 32'd1);
    check(log_n == 7, "R6", "program timeout write count", 32'(log_n), 32'd7);
    chk_wr(4, 7, W_SUSP, "R6"); chk_wr(5, 7, W_CLR, "R6"); chk_wr(6, 7, W_RDM, "R6");
    busy_left = 0;
  endtask

  task automatic t_erase_ok();
    logic [1:0] r;
    clear_log();
    mem[8] = 32'h0; busy_left = 2; err_inj = 32'h0000_0010;
    run_op(1'b1, 22'd8, 32'h0, r);
    check(r == 2'd0, "R4", "erase result ignores error bit", 32'(r), 32'd0);
    check(log_n == 4, "R4", "erase write count", 32'(log_n), 32'd4);
    chk_wr(0, 8, W_CLR, "R4"); chk_wr(1, 8, W_ESET, "R4");
    chk_wr(2, 8, W_ECNF, "R4"); chk_wr(3, 8, W_RDM, "R4");
    check(first_rd_stamp - cnf_stamp >= SETL, "R8", "confirm to first read gap",
          32'(first_rd_stamp - cnf_stamp), 32'(SETL));
    check(rd_n == 3, "R5", "erase poll reads", 32'(rd_n), 32'd3);
    err_inj = 0;
  endtask

  task automatic t_erase_tmo();
    logic [1:0] r;
    clear_log();
    busy_left = 100000;
    run_op(1'b1, 22'd9, 32'h0, r);
    check(r == 2'd1, "R6", "erase timeout result", 32'(r), 32'd1);
    check(log_n == 5, "R6", "erase timeout write count", 32'(log_n), 32'd5);
    chk_wr(3, 9, W_SUSP, "R6"); chk_wr(4, 9, W_RDM, "R6");
    busy_left = 0;
  endtask

  task automatic t_busy_ignore();
    int dones = 0, drops = 0, stray = 0;
    clear_log();
    mem[2] = 32'hFFFF_FFFF; busy_left = 4;
    @(negedge clk);
    req_valid = 1'b1; req_erase = 1'b0; req_addr = 22'd2; req_data = 32'hCAFE_0000;
    @(negedge clk);
    req_erase = 1'b1; req_addr = 22'd11;   // held high while busy: must be ignored
    for (int k = 0; k < 60; k++) begin
      if (done) dones++;
      if (!busy && dones == 0) drops++;
      if (k == 40) req_valid = 1'b0;
      @(negedge clk);
      if (dones > 0) break;
    end
    req_valid = 1'b0;
    for (int k = 0; k < 10; k++) begin
      if (done) dones++;
      if (busy) stray++;
      @(negedge clk);
    end
    check(drops == 0, "R9", "busy held until done", 32'(drops), 32'd0);
    check(dones == 1, "R9", "single done pulse", 32'(dones), 32'd1);
    check(stray == 0, "R9", "no second operation", 32'(stray), 32'd0);
    check(log_n == 6 && log_a[0] == 22'd2, "R9", "log only from first request", 32'(log_n), 32'd6);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_erase = 1'b0; req_addr = '0; req_data = '0;
    fl_rdata = '0; busy_left = 0; err_inj = 0; log_n = 0; rd_n = 0;
    cnf_stamp = -1; first_rd_stamp = -1; rd_mode = 1'b1; pgm_armed = 1'b0;
    for (int i = 0; i < 16; i++) mem[i] = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_prog_ok();
    t_not_erased();
    t_prog_err();
    t_prog_tmo();
    t_erase_ok();
    t_erase_tmo();
    t_busy_ignore();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=<100000 cycles", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule